// File: doc/BRIEF.md
# Counting Semaphore Lock Bank

This block holds a bank of small unsigned counters that DMA channels and a compute core use to pass ownership of shared local buffers back and forth. Each requester asks for one operation at a time on one lock: either a take, which waits until the count reaches a requested threshold and then removes that amount, or a give, which adds an amount back. A producer lock set to 2 lets two buffers be filled ahead of the consumer, which is the usual double-buffering arrangement. A consumer lock set to 0 makes the reader wait until data has been handed over.

Lock start values are written through a configuration port while reset is held. Each cycle, every lock independently picks at most one request that targets it. A give beats a take on the same lock. Among requests of the same kind, the lowest requester index wins. The winner gets a one-cycle grant pulse, and the count changes at the same clock edge. A give that would pass the top of the count range is clamped, and a sticky error flag is raised. A registered query port returns the count of any lock.

Top module: `lock_bank`

## Requirements
- R1: While `rst` is high, a cycle with `cfg_we` high loads `cfg_val` into lock `cfg_id`. A lock not written during reset keeps its previous count. `q_cnt` shows the count of lock `q_id` one clock edge after it is sampled.
- R2: A take (`req_op` bit = 0) on a lock whose count is at least the amount is granted. `req_grant` goes high for exactly one cycle after the edge that samples the request, and the count drops by the amount at that edge.
- R3: A take whose amount exceeds the count gets no grant and leaves the count unchanged while it is held. It is granted in the cycle after a give raises the count enough.
- R4: A give (`req_op` bit = 1) is granted after one edge and adds its amount to the count.
- R5: An amount field of 0 acts as an amount of 1, for both takes and gives.
- R6: A give whose sum exceeds 2^CNT_W-1 (63 by default) sets the count to 63 and sets `err_sat`. `err_sat` then stays high until reset.
- R7: When several requests of the same kind target one lock, the lowest requester index is granted first. The others follow one per cycle.
- R8: When a give and a take target the same lock in the same cycle, the give is granted first. The take is judged against the raised count in the next cycle.
- R9: Requests on different locks are granted in the same cycle.
- R10: A request that is still high in the cycle its grant is shown is ignored in that cycle, so one held request is never granted twice in a row.
- R11: While `rst` is high, `req_grant` is all zero and `err_sat` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Start-value write enable, honoured only in reset |
| cfg_id | input | ID_W (4) | Lock selected for the start-value write |
| cfg_val | input | CNT_W (6) | Start value |
| req_valid | input | NUM_REQ (4) | Per-requester request, held until granted |
| req_op | input | NUM_REQ (4) | Per-requester kind: 0 take, 1 give |
| req_id | input | NUM_REQ*ID_W (16) | Per-requester lock id, requester i in bits [i*ID_W +: ID_W] |
| req_amt | input | NUM_REQ*CNT_W (24) | Per-requester amount, requester i in bits [i*CNT_W +: CNT_W] |
| req_grant | output | NUM_REQ (4) | One-cycle grant pulse per requester |
| err_sat | output | 1 | Sticky flag: a give was clamped |
| q_id | input | ID_W (4) | Lock selected for the count query |
| q_cnt | output | CNT_W (6) | Registered count of lock `q_id` |

## Verification
The properties assume each requester raises `req_valid` only with a stable lock id, kind and amount, and keeps them steady until it sees its grant. They also assume reset is held for at least one edge before the checks rely on the start values. The bench drives every input on the falling edge and changes request fields only after the grant has been observed. It drops a request in the grant cycle, except for one deliberate case that probes the masking of a held request. The bench writes every start value during reset before any requests are made, so no count is ever undefined.

// File: rtl/lockbank_pkg.sv
package lockbank_pkg;
  typedef enum logic {
    OP_TAKE = 1'b0,
    OP_GIVE = 1'b1
  } lk_op_e;
endpackage

// File: rtl/lb_pick.sv
// Per-lock selector: gives first, then takes that fit, lowest index first.
module lb_pick
  import lockbank_pkg::*;
#(
  parameter int NUM_REQ  = 4,
  parameter int ID_W     = 4,
  parameter int CNT_W    = 6,
  parameter int LOCK_IDX = 0
) (
  input  logic [NUM_REQ-1:0]       cand,
  input  logic [NUM_REQ-1:0]       req_op,
  input  logic [NUM_REQ*ID_W-1:0]  req_id,
  input  logic [NUM_REQ*CNT_W-1:0] req_amt,
  input  logic [CNT_W-1:0]         cur_cnt,
  output logic [NUM_REQ-1:0]       win,
  output logic                     upd_en,
  output logic                     upd_give,
  output logic [CNT_W-1:0]         upd_amt
);
  localparam logic [ID_W-1:0] MY_ID = ID_W'(LOCK_IDX);

  logic [NUM_REQ-1:0] give_hit;
  logic [NUM_REQ-1:0] take_ok;
  logic [CNT_W-1:0]   amt_eff [NUM_REQ];

  always_comb begin
    for (int i = 0; i < NUM_REQ; i++) begin
      amt_eff[i] = req_amt[i*CNT_W +: CNT_W];
      if (amt_eff[i] == '0) amt_eff[i] = CNT_W'(1);
      give_hit[i] = cand[i] && (req_id[i*ID_W +: ID_W] == MY_ID) &&
                    (req_op[i] == OP_GIVE);
      take_ok[i]  = cand[i] && (req_id[i*ID_W +: ID_W] == MY_ID) &&
                    (req_op[i] == OP_TAKE) && (cur_cnt >= amt_eff[i]);
    end
  end

  always_comb begin
    logic found;
    win     = '0;
    found   = 1'b0;
    upd_amt = '0;
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!found && give_hit[i]) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      if (!found && take_ok[i]) begin
        win[i] = 1'b1;
        found  = 1'b1;
      end
    end
    for (int i = 0; i < NUM_REQ; i++) begin
      if (win[i]) upd_amt = amt_eff[i];
    end
    upd_en   = found;
    upd_give = |give_hit;
  end
endmodule

// File: rtl/lb_cell.sv
// One lock counter: start-value load in reset, clamped add, subtract.
module lb_cell #(
  parameter int CNT_W    = 6,
  parameter int ID_W     = 4,
  parameter int LOCK_IDX = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_we,
  input  logic [ID_W-1:0]  cfg_id,
  input  logic [CNT_W-1:0] cfg_val,
  input  logic             upd_en,
  input  logic             upd_give,
  input  logic [CNT_W-1:0] upd_amt,
  output logic [CNT_W-1:0] cnt,
  output logic             sat_hit
);
  localparam logic [ID_W-1:0]  MY_ID   = ID_W'(LOCK_IDX);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W:0] sum;

  always_comb begin
    sum     = {1'b0, cnt} + {1'b0, upd_amt};
    sat_hit = !rst && upd_en && upd_give && sum[CNT_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      if (cfg_we && cfg_id == MY_ID) cnt <= cfg_val;
    end else if (upd_en) begin
      if (upd_give) cnt <= sum[CNT_W] ? CNT_MAX : sum[CNT_W-1:0];
      else          cnt <= cnt - upd_amt;
    end
  end
endmodule

// File: rtl/lock_bank.sv
module lock_bank #(
  parameter int NUM_LOCKS = 16,
  parameter int NUM_REQ   = 4,
  parameter int CNT_W     = 6,
  localparam int ID_W     = $clog2(NUM_LOCKS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     cfg_we,
  input  logic [ID_W-1:0]          cfg_id,
  input  logic [CNT_W-1:0]         cfg_val,
  input  logic [NUM_REQ-1:0]       req_valid,
  input  logic [NUM_REQ-1:0]       req_op,
  input  logic [NUM_REQ*ID_W-1:0]  req_id,
  input  logic [NUM_REQ*CNT_W-1:0] req_amt,
  output logic [NUM_REQ-1:0]       req_grant,
  output logic                     err_sat,
  input  logic [ID_W-1:0]          q_id,
  output logic [CNT_W-1:0]         q_cnt
);
  logic [NUM_REQ-1:0]         cand;
  logic [NUM_LOCKS*CNT_W-1:0] cnt_flat;
  logic [NUM_LOCKS*NUM_REQ-1:0] win_flat;
  logic [NUM_LOCKS-1:0]       sat_vec;
  logic [NUM_REQ-1:0]         grant_d;

  // A requester whose grant is on show this cycle is masked out.
  assign cand = req_valid & ~req_grant;

  for (genvar L = 0; L < NUM_LOCKS; L++) begin : g_lock
    logic             upd_en;
    logic             upd_give;
    logic [CNT_W-1:0] upd_amt;

    lb_pick #(
      .NUM_REQ(NUM_REQ), .ID_W(ID_W), .CNT_W(CNT_W), .LOCK_IDX(L)
    ) u_pick (
      .cand    (cand),
      .req_op  (req_op),
      .req_id  (req_id),
      .req_amt (req_amt),
      .cur_cnt (cnt_flat[L*CNT_W +: CNT_W]),
      .win     (win_flat[L*NUM_REQ +: NUM_REQ]),
      .upd_en  (upd_en),
      .upd_give(upd_give),
      .upd_amt (upd_amt)
    );

    lb_cell #(
      .CNT_W(CNT_W), .ID_W(ID_W), .LOCK_IDX(L)
    ) u_cell (
      .clk     (clk),
      .rst     (rst),
      .cfg_we  (cfg_we),
      .cfg_id  (cfg_id),
      .cfg_val (cfg_val),
      .upd_en  (upd_en),
      .upd_give(upd_give),
      .upd_amt (upd_amt),
      .cnt     (cnt_flat[L*CNT_W +: CNT_W]),
      .sat_hit (sat_vec[L])
    );
  end

  always_comb begin
    grant_d = '0;
    for (int L = 0; L < NUM_LOCKS; L++) begin
      grant_d = grant_d | win_flat[L*NUM_REQ +: NUM_REQ];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      req_grant <= '0;
      err_sat   <= 1'b0;
    end else begin
      req_grant <= grant_d;
      err_sat   <= err_sat | (|sat_vec);
    end
    q_cnt <= cnt_flat[q_id*CNT_W +: CNT_W];
  end
endmodule

// File: rtl/lb_checker.sv
module lb_checker #(
  parameter int NUM_REQ = 4
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_REQ-1:0] req_valid,
  input logic [NUM_REQ-1:0] req_grant,
  input logic               err_sat
);
  for (genvar i = 0; i < NUM_REQ; i++) begin : g_req
    p_grant_needs_req_r2: assert property (@(posedge clk) disable iff (rst)
      req_grant[i] |-> $past(req_valid[i]));
    p_grant_pulse_r10: assert property (@(posedge clk) disable iff (rst)
      req_grant[i] |=> !req_grant[i]);
  end

  p_err_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    err_sat |=> err_sat);

  p_reset_quiet_r11: assert property (@(posedge clk)
    rst |=> (req_grant == '0 && !err_sat));
endmodule

bind lock_bank lb_checker #(.NUM_REQ(NUM_REQ)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .req_valid(req_valid),
  .req_grant(req_grant),
  .err_sat  (err_sat)
);

// File: tb/sim_lock_bank.sv
`timescale 1ns/1ps
module sim_lock_bank;
  localparam int NL = 16, NR = 4, CW = 6, IW = 4;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           cfg_we = 1'b0;
  logic [IW-1:0]  cfg_id = '0;
  logic [CW-1:0]  cfg_val = '0;
  logic [NR-1:0]  req_valid = '0;
  logic [NR-1:0]  req_op = '0;
  logic [NR*IW-1:0] req_id = '0;
  logic [NR*CW-1:0] req_amt = '0;
  logic [NR-1:0]  req_grant;
  logic           err_sat;
  logic [IW-1:0]  q_id = '0;
  logic [CW-1:0]  q_cnt;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  lock_bank #(.NUM_LOCKS(NL), .NUM_REQ(NR), .CNT_W(CW)) u0 (.*);

  typedef struct { int exp; int lk; string tag; } sb_item_t;
  sb_item_t sb_q[$];
  logic probe = 1'b0;
  logic probe_d = 1'b0;

  always @(posedge clk) probe_d <= probe;

  // Monitor: pops one expected count per probed query.
  initial forever begin
    @(negedge clk);
    if (probe_d && sb_q.size() > 0) begin
      sb_item_t it;
      it = sb_q.pop_front();
      checks++;
      if (int'(q_cnt) != it.exp) begin
        errors++;
        $display("FAIL %s lock %0d count actual=%0d expected=%0d", it.tag, it.lk, q_cnt, it.exp);
      end
    end
  end

  task automatic expect_cnt(input int lk, input int exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    q_id = IW'(lk);
    probe = 1'b1;
    it.exp = exp; it.lk = lk; it.tag = tag;
    sb_q.push_back(it);
    @(negedge clk);
    probe = 1'b0;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic set_req(input int i, input bit v, input bit op, input int lk, input int amt);
    req_valid[i] = v;
    req_op[i] = op;
    req_id[i*IW +: IW] = IW'(lk);
    req_amt[i*CW +: CW] = CW'(amt);
  endtask

  function automatic int init_of(input int k);
    case (k)
      0: return 1;
      1: return 0;
      2: return 2;
      3: return 62;
      default: return k;
    endcase
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // Load start values in reset (R1), then check reset outputs (R11).
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      cfg_we = 1'b1; cfg_id = IW'(k); cfg_val = CW'(init_of(k));
    end
    @(negedge clk);
    cfg_we = 1'b0;
    chk("R11 grant in reset", int'(req_grant), 0);
    chk("R11 err in reset", int'(err_sat), 0);
    rst = 1'b0;
    expect_cnt(0, 1, "R1");
    expect_cnt(1, 0, "R1");
    expect_cnt(2, 2, "R1");
    expect_cnt(3, 62, "R1");
    expect_cnt(9, 9, "R1");

    // R2: take 2 from lock 2 (count 2).
    @(negedge clk); set_req(0, 1, 0, 2, 2);
    @(negedge clk); chk("R2 grant", int'(req_grant[0]), 1);
    set_req(0, 0, 0, 0, 0);
    @(negedge clk); chk("R2 pulse ends", int'(req_grant[0]), 0);
    expect_cnt(2, 0, "R2");

    // R3: take on empty lock 1 waits, then a give from requester 2 frees it.
    @(negedge clk); set_req(1, 1, 0, 1, 1);
    for (int c = 0; c < 3; c++) begin
      @(negedge clk); chk("R3 blocked take", int'(req_grant[1]), 0);
    end
    set_req(2, 1, 1, 1, 1);
    @(negedge clk);
    chk("R3 give first", int'(req_grant[2]), 1);
    chk("R3 take still waits", int'(req_grant[1]), 0);
    set_req(2, 0, 0, 0, 0);
    @(negedge clk); chk("R3 take granted", int'(req_grant[1]), 1);
    set_req(1, 0, 0, 0, 0);
    expect_cnt(1, 0, "R3");

    // R4: give 10 to lock 1.
    @(negedge clk); set_req(3, 1, 1, 1, 10);
    @(negedge clk); chk("R4 grant", int'(req_grant[3]), 1);
    set_req(3, 0, 0, 0, 0);
    expect_cnt(1, 10, "R4");

    // R8: take and give on lock 0 (count 1) in the same cycle.
    @(negedge clk); set_req(0, 1, 0, 0, 1); set_req(3, 1, 1, 0, 1);
    @(negedge clk);
    chk("R8 give first", int'(req_grant[3]), 1);
    chk("R8 take deferred", int'(req_grant[0]), 0);
    set_req(3, 0, 0, 0, 0);
    @(negedge clk); chk("R8 take next", int'(req_grant[0]), 1);
    set_req(0, 0, 0, 0, 0);
    expect_cnt(0, 1, "R8");

    // R7: two takes on lock 4, two gives on lock 5.
    @(negedge clk); set_req(1, 1, 0, 4, 1); set_req(2, 1, 0, 4, 1);
    @(negedge clk);
    chk("R7 low index take", int'(req_grant), 4'b0010);
    set_req(1, 0, 0, 0, 0);
    @(negedge clk); chk("R7 second take", int'(req_grant), 4'b0100);
    set_req(2, 0, 0, 0, 0);
    expect_cnt(4, 2, "R7");
    @(negedge clk); set_req(0, 1, 1, 5, 1); set_req(3, 1, 1, 5, 1);
    @(negedge clk);
    chk("R7 low index give", int'(req_grant), 4'b0001);
    set_req(0, 0, 0, 0, 0);
    @(negedge clk); chk("R7 second give", int'(req_grant), 4'b1000);
    set_req(3, 0, 0, 0, 0);
    expect_cnt(5, 7, "R7");

    // R9: different locks in the same cycle.
    @(negedge clk); set_req(0, 1, 0, 6, 3); set_req(1, 1, 1, 7, 2);
    @(negedge clk); chk("R9 both granted", int'(req_grant), 4'b0011);
    set_req(0, 0, 0, 0, 0); set_req(1, 0, 0, 0, 0);
    expect_cnt(6, 3, "R9");
    expect_cnt(7, 9, "R9");

    // R5: amount 0 acts as 1.
    @(negedge clk); set_req(2, 1, 0, 8, 0);
    @(negedge clk); chk("R5 take grant", int'(req_grant[2]), 1);
    set_req(2, 0, 0, 0, 0);
    expect_cnt(8, 7, "R5");
    @(negedge clk); set_req(2, 1, 1, 8, 0);
    @(negedge clk); chk("R5 give grant", int'(req_grant[2]), 1);
    set_req(2, 0, 0, 0, 0);
    expect_cnt(8, 8, "R5");

    // R10: a take held through its grant cycle is applied once.
    @(negedge clk); set_req(0, 1, 0, 9, 1);
    @(negedge clk); chk("R10 grant", int'(req_grant[0]), 1);
    @(negedge clk); chk("R10 masked", int'(req_grant[0]), 0);
    set_req(0, 0, 0, 0, 0);
    expect_cnt(9, 8, "R10");

    // R6: saturating give on lock 3 (62 + 5).
    @(negedge clk); chk("R6 err before", int'(err_sat), 0);
    set_req(1, 1, 1, 3, 5);
    @(negedge clk);
    chk("R6 grant", int'(req_grant[1]), 1);
    chk("R6 err set", int'(err_sat), 1);
    set_req(1, 0, 0, 0, 0);
    expect_cnt(3, 63, "R6");
    @(negedge clk); set_req(1, 1, 0, 3, 1);
    @(negedge clk); set_req(1, 0, 0, 0, 0);
    @(negedge clk); chk("R6 err sticky", int'(err_sat), 1);
    expect_cnt(3, 62, "R6");

    // R11 and R1: reset again without writes; error clears, counts held.
    @(negedge clk); rst = 1'b1;
    @(negedge clk);
    chk("R11 err cleared", int'(err_sat), 0);
    chk("R11 no grant", int'(req_grant), 0);
    expect_cnt(3, 62, "R1 hold");
    rst = 1'b0;
    expect_cnt(4, 2, "R1 hold");

    repeat (3) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule